// File: doc/BRIEF.md
# Coverage Bin Collector

This block watches a 10-bit value and sorts it, whenever its sample strobe is high on a rising clock edge, into a fixed set of coverage bins. Two bins are scalar: one takes any value of a low range plus one extra value, the other takes a high range. Two bins are arrays with one bin per value: one spans the union of two overlapping ranges and one spans a short run of three values. A value that lands in no bin falls to the default class. An ignore range and an illegal range sit above all the bins in precedence.

Each bin has a sticky hit flag. The block counts the bins that have been hit and turns the count into an integer percentage of the countable bins. It raises a level flag once the percentage reaches a parameter threshold. A sample in the illegal range raises a sticky halt, and the block then ignores every later sample until a clear. It is meant to sit beside a datapath in simulation or in silicon bring-up, where it shows how much of a value space traffic has exercised.

Top module: `cov_bin_collector`

## Requirements
- R1: After a synchronous reset, hit_count, coverage_pct, done and illegal_halt are all 0.
- R2: Values 0..63 and the value 65 all feed one scalar bin, so hitting any number of them raises hit_count by exactly 1. The value 64 belongs to no bin.
- R3: Each value of 127..191 has its own bin, 65 bins in all. The values 148..150 lie in both defining ranges (127..150 and 148..191) and each still owns a single bin.
- R4: The values 200, 201 and 202 own one bin each. The values 1000..1023 share one scalar bin.
- R5: A default-class value (one in no bin, not ignored, not illegal) leaves hit_count unchanged.
- R6: Values 140..143 are ignored even though they lie inside the per-value range. A sample of one of them changes nothing, and their bins are left out of the countable total, which is therefore 66.
- R7: A sample in 512..515 sets illegal_halt, which stays set. While it is set, samples leave hit_count unchanged.
- R8: A value presented while sample_en is 0 has no effect.
- R9: hit_count shows a sample on the clock edge that takes it. coverage_pct equals floor(100 × hit_count / 66) one cycle later and reaches 100 when every countable bin has been hit.
- R10: done is 1 exactly when coverage_pct is at least DONE_PCT, which defaults to 60. This means from 40 hit bins on.
- R11: clr zeroes hit_count, all hit flags and illegal_halt in one edge, and wins over a sample taken in the same cycle.
- R12: Hitting a bin that is already hit does not raise hit_count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample strobe |
| sample_val | input | 10 | Value to classify |
| clr | input | 1 | Clear all hit flags, the count and the halt |
| hit_count | output | 7 | Number of countable bins hit |
| coverage_pct | output | 7 | Integer coverage percentage |
| done | output | 1 | Coverage at or above threshold |
| illegal_halt | output | 1 | Sticky illegal-hit flag |

## Verification
The bench builds the block with its default bin layout and a DONE_PCT of 60. With 66 countable bins, the threshold falls between 39 and 40 hits, so a full sweep of the value space walks done across that boundary one bin at a time and also reaches 100 percent. Those defaults place the ignore range inside the overlapping per-value array and the illegal range in the default gap. That brings precedence, duplicate suppression and the halt-then-clear sequence within reach of short directed tests.

// File: rtl/cov_pkg.sv
`timescale 1ns/1ps
package cov_pkg;
  localparam int VAL_W = 10;
  typedef logic [VAL_W-1:0] val_t;

  typedef struct packed {
    val_t a_lo, a_hi, a_one;
    val_t b1_lo, b1_hi, b2_lo, b2_hi;
    val_t c_lo, c_hi;
    val_t d_lo, d_hi;
    val_t ign_lo, ign_hi;
    val_t ill_lo, ill_hi;
  } bin_spec_t;

  localparam bin_spec_t DEFAULT_SPEC = '{
    a_lo: 10'd0,    a_hi: 10'd63,   a_one: 10'd65,
    b1_lo: 10'd127, b1_hi: 10'd150, b2_lo: 10'd148, b2_hi: 10'd191,
    c_lo: 10'd200,  c_hi: 10'd202,
    d_lo: 10'd1000, d_hi: 10'd1023,
    ign_lo: 10'd140, ign_hi: 10'd143,
    ill_lo: 10'd512, ill_hi: 10'd515};

  typedef enum logic [1:0] {CL_DEFAULT, CL_IGNORE, CL_ILLEGAL, CL_BIN} cls_e;

  function automatic logic in_rng(val_t v, val_t lo, val_t hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic int b_base(bin_spec_t s);
    return (s.b1_lo < s.b2_lo) ? int'(s.b1_lo) : int'(s.b2_lo);
  endfunction

  function automatic int b_span(bin_spec_t s);
    int top;
    top = (s.b1_hi > s.b2_hi) ? int'(s.b1_hi) : int'(s.b2_hi);
    return top - b_base(s) + 1;
  endfunction

  function automatic int c_span(bin_spec_t s);
    return int'(s.c_hi) - int'(s.c_lo) + 1;
  endfunction

  function automatic int n_bins(bin_spec_t s);
    return 2 + b_span(s) + c_span(s);
  endfunction

  function automatic logic is_b(val_t v, bin_spec_t s);
    return in_rng(v, s.b1_lo, s.b1_hi) || in_rng(v, s.b2_lo, s.b2_hi);
  endfunction

  // Scalar bins always count; per-value bins count unless ignored or illegal.
  function automatic int count_countable(bin_spec_t s);
    int n;
    val_t vv;
    n = 2;
    for (int v = 0; v < (1 << VAL_W); v++) begin
      vv = val_t'(v);
      if ((is_b(vv, s) || in_rng(vv, s.c_lo, s.c_hi)) &&
          !in_rng(vv, s.ign_lo, s.ign_hi) && !in_rng(vv, s.ill_lo, s.ill_hi))
        n++;
    end
    return n;
  endfunction
endpackage

// File: rtl/cov_classifier.sv
`timescale 1ns/1ps
module cov_classifier
  import cov_pkg::*;
#(
  parameter bin_spec_t SPEC  = DEFAULT_SPEC,
  parameter int        IDX_W = 7
) (
  input  val_t              value,
  output cls_e              cls,
  output logic [IDX_W-1:0]  idx
);
  localparam int NB    = n_bins(SPEC);
  localparam int BBASE = b_base(SPEC);
  localparam int BSPAN = b_span(SPEC);

  // Precedence: illegal, ignore, scalar low, scalar high, arrays, default.
  always_comb begin
    cls = CL_DEFAULT;
    idx = '0;
    if (in_rng(value, SPEC.ill_lo, SPEC.ill_hi)) begin
      cls = CL_ILLEGAL;
    end else if (in_rng(value, SPEC.ign_lo, SPEC.ign_hi)) begin
      cls = CL_IGNORE;
    end else if (in_rng(value, SPEC.a_lo, SPEC.a_hi) || value == SPEC.a_one) begin
      cls = CL_BIN;
      idx = '0;
    end else if (in_rng(value, SPEC.d_lo, SPEC.d_hi)) begin
      cls = CL_BIN;
      idx = IDX_W'(NB - 1);
    end else if (is_b(value, SPEC)) begin
      cls = CL_BIN;
      idx = IDX_W'(1 + int'(value) - BBASE);
    end else if (in_rng(value, SPEC.c_lo, SPEC.c_hi)) begin
      cls = CL_BIN;
      idx = IDX_W'(1 + BSPAN + int'(value) - int'(SPEC.c_lo));
    end
  end
endmodule

// File: rtl/cov_hit_store.sv
`timescale 1ns/1ps
module cov_hit_store
  import cov_pkg::*;
#(
  parameter int NBINS = 70,
  parameter int IDX_W = 7,
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sample_en,
  input  cls_e              cls,
  input  logic [IDX_W-1:0]  idx,
  output logic [CNT_W-1:0]  hit_count,
  output logic              illegal_halt
);
  logic [NBINS-1:0] flags;
  logic             take;

  assign take = sample_en && !illegal_halt && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags        <= '0;
      hit_count    <= '0;
      illegal_halt <= 1'b0;
    end else if (take) begin
      if (cls == CL_ILLEGAL) begin
        illegal_halt <= 1'b1;
      end else if (cls == CL_BIN && !flags[idx]) begin
        flags[idx] <= 1'b1;
        hit_count  <= hit_count + CNT_W'(1);
      end
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + CNT_W'(1))); // R12
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (illegal_halt && !clr) |=> (illegal_halt && $stable(hit_count))); // R7
  AST_ILLEGAL_SETS: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !clr && cls == CL_ILLEGAL) |=> illegal_halt); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (hit_count == '0 && !illegal_halt)); // R11
  AST_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (!sample_en && !clr) |=> $stable(hit_count)); // R8
endmodule

// File: rtl/cov_percent.sv
`timescale 1ns/1ps
module cov_percent #(
  parameter int NCOUNT   = 66,
  parameter int CNT_W    = 7,
  parameter int PCT_W    = 7,
  parameter int DONE_PCT = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  hit_count,
  output logic [PCT_W-1:0]  coverage_pct,
  output logic              done
);
  logic [PCT_W-1:0] pct_next;

  always_comb begin
    if (NCOUNT > 0) pct_next = PCT_W'((int'(hit_count) * 100) / NCOUNT);
    else            pct_next = PCT_W'(100);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coverage_pct <= '0;
      done         <= 1'b0;
    end else begin
      coverage_pct <= pct_next;
      done         <= (int'(pct_next) >= DONE_PCT);
    end
  end

  AST_PCT_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(coverage_pct) <= 100); // R9
  AST_DONE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    done |-> int'(coverage_pct) >= DONE_PCT); // R10
endmodule

// File: rtl/cov_bin_collector.sv
`timescale 1ns/1ps
module cov_bin_collector
  import cov_pkg::*;
#(
  parameter bin_spec_t SPEC     = DEFAULT_SPEC,
  parameter int        DONE_PCT = 60,
  localparam int       NCOUNT   = count_countable(SPEC),
  localparam int       CNT_W    = $clog2(NCOUNT + 1),
  localparam int       PCT_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_en,
  input  logic [VAL_W-1:0]     sample_val,
  input  logic                 clr,
  output logic [CNT_W-1:0]     hit_count,
  output logic [PCT_W-1:0]     coverage_pct,
  output logic                 done,
  output logic                 illegal_halt
);
  localparam int NBINS = n_bins(SPEC);
  localparam int IDX_W = $clog2(NBINS);

  cls_e             cls;
  logic [IDX_W-1:0] idx;

  cov_classifier #(.SPEC(SPEC), .IDX_W(IDX_W)) u_cls (
    .value (sample_val),
    .cls   (cls),
    .idx   (idx)
  );

  cov_hit_store #(.NBINS(NBINS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
    .clk          (clk),
    .rst          (rst),
    .clr          (clr),
    .sample_en    (sample_en),
    .cls          (cls),
    .idx          (idx),
    .hit_count    (hit_count),
    .illegal_halt (illegal_halt)
  );

  cov_percent #(.NCOUNT(NCOUNT), .CNT_W(CNT_W), .PCT_W(PCT_W), .DONE_PCT(DONE_PCT)) u_pct (
    .clk          (clk),
    .rst          (rst),
    .hit_count    (hit_count),
    .coverage_pct (coverage_pct),
    .done         (done)
  );

  AST_IGNORE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !clr && cls == CL_IGNORE) |=> $stable(hit_count)); // R6
  AST_DEFAULT_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !clr && cls == CL_DEFAULT) |=> $stable(hit_count)); // R5
endmodule

// File: tb/sim_cov_bin_collector.sv
`timescale 1ns/1ps
module sim_cov_bin_collector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_en = 1'b0;
  logic [9:0] sample_val = '0;
  logic       clr = 1'b0;
  logic [6:0] hit_count;
  logic [6:0] coverage_pct;
  logic       done;
  logic       illegal_halt;

  int checks = 0;
  int fails  = 0;
  int mcount = 0;
  bit mseen [0:1023];

  localparam int NCOUNT = 66;
  localparam int THR    = 60;

  always #5 clk = ~clk;

  cov_bin_collector u0 (
    .clk(clk), .rst(rst), .sample_en(sample_en), .sample_val(sample_val),
    .clr(clr), .hit_count(hit_count), .coverage_pct(coverage_pct),
    .done(done), .illegal_halt(illegal_halt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // -2 illegal, -1 no bin (ignored or default), otherwise representative value of the bin
  function automatic int bin_key(int v);
    if (v >= 512 && v <= 515) return -2;
    if (v >= 140 && v <= 143) return -1;
    if (v <= 63 || v == 65)   return 0;
    if (v >= 1000)            return 1000;
    if (v >= 127 && v <= 191) return v;
    if (v >= 200 && v <= 202) return v;
    return -1;
  endfunction

  function automatic void model_clear();
    foreach (mseen[i]) mseen[i] = 1'b0;
    mcount = 0;
  endfunction

  function automatic void model_hit(int v);
    int k;
    k = bin_key(v);
    if (k >= 0 && !mseen[k]) begin
      mseen[k] = 1'b1;
      mcount++;
    end
  endfunction

  task automatic sample(input int v);
    @(negedge clk);
    sample_en  = 1'b1;
    sample_val = 10'(v);
    @(negedge clk);
    sample_en  = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_clear();
    idle();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    chk(hit_count == 0, "R1 hit_count", hit_count, 0);
    chk(coverage_pct == 0, "R1 coverage_pct", coverage_pct, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(illegal_halt == 0, "R1 illegal_halt", illegal_halt, 0);
  endtask

  task automatic t_scalar();
    sample(5);
    chk(hit_count == 1, "R2 first low value", hit_count, 1);
    sample(65);
    chk(hit_count == 1, "R2 extra value same bin", hit_count, 1);
    sample(63);
    chk(hit_count == 1, "R2 top of range same bin", hit_count, 1);
    sample(64);
    chk(hit_count == 1, "R5 default value 64", hit_count, 1);
    sample(600);
    chk(hit_count == 1, "R5 default value 600", hit_count, 1);
  endtask

  task automatic t_array();
    sample(148); sample(149); sample(150);
    chk(hit_count == 4, "R3 overlap values own one bin each", hit_count, 4);
    sample(148);
    chk(hit_count == 4, "R12 repeat hit", hit_count, 4);
  endtask

  task automatic t_c_d();
    sample(200); sample(201); sample(202);
    chk(hit_count == 7, "R4 three value bins", hit_count, 7);
    sample(1000); sample(1023);
    chk(hit_count == 8, "R4 high scalar bin", hit_count, 8);
  endtask

  task automatic t_ignore();
    for (int v = 140; v <= 143; v++) sample(v);
    chk(hit_count == 8, "R6 ignored values", hit_count, 8);
  endtask

  task automatic t_enable();
    @(negedge clk);
    sample_val = 10'd130;
    repeat (3) @(negedge clk);
    chk(hit_count == 8, "R8 disabled sample", hit_count, 8);
  endtask

  task automatic t_pct();
    idle();
    chk(coverage_pct == 12, "R9 pct for 8 bins", coverage_pct, 12);
    sample(130);
    chk(hit_count == 9, "R9 count on sample edge", hit_count, 9);
    chk(coverage_pct == 12, "R9 pct lags one cycle", coverage_pct, 12);
    idle();
    chk(coverage_pct == 13, "R9 pct for 9 bins", coverage_pct, 13);
  endtask

  task automatic t_illegal();
    sample(513);
    chk(illegal_halt == 1, "R7 halt set", illegal_halt, 1);
    chk(hit_count == 9, "R7 illegal not counted", hit_count, 9);
    sample(131);
    chk(hit_count == 9, "R7 sampling stopped", hit_count, 9);
    chk(illegal_halt == 1, "R7 halt sticky", illegal_halt, 1);
  endtask

  task automatic t_clear();
    @(negedge clk);
    clr = 1'b1; sample_en = 1'b1; sample_val = 10'd132;
    @(negedge clk);
    clr = 1'b0; sample_en = 1'b0;
    chk(hit_count == 0, "R11 count cleared over sample", hit_count, 0);
    chk(illegal_halt == 0, "R11 halt cleared", illegal_halt, 0);
    idle();
    chk(coverage_pct == 0, "R11 pct back to zero", coverage_pct, 0);
    chk(done == 0, "R11 done back to zero", done, 0);
    sample(132);
    chk(hit_count == 1, "R11 sampling resumes", hit_count, 1);
  endtask

  task automatic t_sweep();
    int ep;
    bit first_done_ok;
    do_clear();
    first_done_ok = 1'b1;
    for (int v = 0; v < 1024; v++) begin
      if (v >= 512 && v <= 515) continue;
      sample(v);
      model_hit(v);
      chk(int'(hit_count) == mcount, "R3 sweep count", hit_count, mcount);
      idle();
      ep = (mcount * 100) / NCOUNT;
      chk(int'(coverage_pct) == ep, "R9 sweep pct", coverage_pct, ep);
      chk(done == (ep >= THR), "R10 sweep done", done, int'(ep >= THR));
      if (mcount == 39 && done) first_done_ok = 1'b0;
      if (mcount == 40 && !done) first_done_ok = 1'b0;
    end
    chk(first_done_ok, "R10 threshold between 39 and 40 bins", first_done_ok, 1);
    chk(hit_count == 66, "R6 countable total", hit_count, 66);
    chk(coverage_pct == 100, "R9 full coverage", coverage_pct, 100);
    sample(514);
    chk(illegal_halt == 1, "R7 halt after sweep", illegal_halt, 1);
    do_clear();
  endtask

  initial begin
    model_clear();
    t_reset();
    t_scalar();
    t_array();
    t_c_d();
    t_ignore();
    t_enable();
    t_pct();
    t_illegal();
    t_clear();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule